// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is the local event timer of a single processor core. Two counters run in series. A prescaler reloads from a tick buffer and emits one tick every (buffer + 1) input clocks. An event counter, loaded from an event buffer, counts those ticks down and flags an event when it expires. In auto-reload mode the event counter refills from its buffer and keeps firing. Otherwise it fires once and then waits for a fresh start.

Software reaches the block through a simple synchronous register bus. Each write that changes a buffer or the control register is acknowledged by a write-one-to-clear acknowledge bit. The event status bit is also write-one-to-clear. The interrupt line is the status bit gated by the enable bit.

Top module: `core_tick_timer`

## Requirements
- R1: After a synchronous reset, every readable register reads zero and `irq` is low.
- R2: Each register is at a fixed byte offset. The tick buffer at 0x00 reads back all 32 bits. The event buffer at 0x08 reads back bits 30:0, and bit 31 always reads 0. Control at 0x20 keeps bits 2:0 only. Enable at 0x34 keeps bit 0 only. Any unmapped offset reads zero.
- R3: Control bit 0 runs the prescaler and bit 1 runs the event counter; a start sets the bit from 0 to 1 and reloads that counter from its buffer. With tick buffer T and event buffer N (N ≥ 1), status bit 0 is set (N)·(T+1) clocks after the edge that wrote the starting control value.
- R4: A write to 0x08 with bit 31 set loads bits 30:0 straight into the running event counter. A write with bit 31 clear changes only the buffer, and the buffer is used at the next reload.
- R5: With control bit 2 set, the event counter reloads at each expiry, and the next event follows N·(T+1) clocks later.
- R6: With control bit 2 clear, the event counter fires once and then stays idle. It fires again only after bit 1 is cleared and set again.
- R7: Clearing control bit 0 freezes the prescaler, and so the event counter, at once. Setting bit 0 again reloads the prescaler only, and the event counter resumes from its held count.
- R8: Status bit 0 at 0x30 is set by an expiry and cleared by writing 1 to it. An expiry in the same cycle as the clear wins.
- R9: `irq` is high exactly when status bit 0 and enable bit 0 are both set.
- R10: The acknowledge register at 0x40 sets bit 0 on a write to 0x00, bit 1 on a write to 0x08 and bit 3 on a write to 0x20. Writing 1 to a bit clears it. Writes to other offsets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the strobe |
| irq | output | 1 | Event interrupt, status gated by enable |

## Verification
The bench builds the block with its default 32-bit data width, 8-bit offset and 32-bit tick buffer. It then programs small tick and event buffer values (0 to 3 ticks, 2 to 10 events), so each expiry lands within a dozen clocks and its cycle can be predicted exactly. These short buffers bring the first-expiry spacing, the auto-reload spacing, the freeze-and-resume case and the immediate-load race within a few hundred cycles. The all-ones write checks that the 31-bit event buffer drops its top bit.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    localparam int OFS_TBUF  = 'h00;
    localparam int OFS_EBUF  = 'h08;
    localparam int OFS_CTRL  = 'h20;
    localparam int OFS_STAT  = 'h30;
    localparam int OFS_IEN   = 'h34;
    localparam int OFS_WACK  = 'h40;

    typedef struct packed {
        logic reload_mode;
        logic evt_run;
        logic tick_run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic ebuf;
        logic tbuf;
    } wack_t;

    typedef enum logic [2:0] {
        RS_NONE, RS_TBUF, RS_EBUF, RS_CTRL, RS_STAT, RS_IEN, RS_WACK
    } regsel_e;

    function automatic regsel_e decode_ofs(input int ofs);
        case (ofs)
            OFS_TBUF: return RS_TBUF;
            OFS_EBUF: return RS_EBUF;
            OFS_CTRL: return RS_CTRL;
            OFS_STAT: return RS_STAT;
            OFS_IEN:  return RS_IEN;
            OFS_WACK: return RS_WACK;
            default:  return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
    import ctt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int TICK_W = 32,
    parameter int EVT_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire_i,
    output logic [TICK_W-1:0] tick_buf_o,
    output logic [EVT_W-1:0]  evt_buf_o,
    output ctrl_t             ctrl_o,
    output logic              tick_start_o,
    output logic              evt_start_o,
    output logic              evt_load_o,
    output logic [EVT_W-1:0]  evt_load_val_o,
    output logic              irq_o
);
    regsel_e sel;
    logic    wr, wr_t, wr_e, wr_c, wr_s, wr_i, wr_a;
    ctrl_t   ctrl_q, ctrl_new;
    wack_t   wack_q;
    logic    stat_q, ien_q;
    logic [TICK_W-1:0] tbuf_q;
    logic [EVT_W-1:0]  ebuf_q;

    always_comb begin
        sel  = decode_ofs(int'(bus_addr));
        wr   = bus_en && bus_we;
        wr_t = wr && (sel == RS_TBUF);
        wr_e = wr && (sel == RS_EBUF);
        wr_c = wr && (sel == RS_CTRL);
        wr_s = wr && (sel == RS_STAT);
        wr_i = wr && (sel == RS_IEN);
        wr_a = wr && (sel == RS_WACK);
        ctrl_new = ctrl_t'(bus_wdata[2:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbuf_q <= '0;
            ebuf_q <= '0;
            ctrl_q <= '0;
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
            wack_q <= '0;
        end else begin
            if (wr_t) tbuf_q <= bus_wdata[TICK_W-1:0];
            if (wr_e) ebuf_q <= bus_wdata[EVT_W-1:0];
            if (wr_c) ctrl_q <= ctrl_new;
            if (wr_i) ien_q  <= bus_wdata[0];
            if (expire_i)                stat_q <= 1'b1;
            else if (wr_s && bus_wdata[0]) stat_q <= 1'b0;
            if (wr_a) begin
                if (bus_wdata[0]) wack_q.tbuf <= 1'b0;
                if (bus_wdata[1]) wack_q.ebuf <= 1'b0;
                if (bus_wdata[3]) wack_q.ctrl <= 1'b0;
            end
            if (wr_t) wack_q.tbuf <= 1'b1;
            if (wr_e) wack_q.ebuf <= 1'b1;
            if (wr_c) wack_q.ctrl <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_TBUF: bus_rdata = DATA_W'(tbuf_q);
            RS_EBUF: bus_rdata = DATA_W'(ebuf_q);
            RS_CTRL: bus_rdata = DATA_W'(ctrl_q);
            RS_STAT: bus_rdata = DATA_W'(stat_q);
            RS_IEN:  bus_rdata = DATA_W'(ien_q);
            RS_WACK: bus_rdata = DATA_W'({wack_q.ctrl, 1'b0, wack_q.ebuf, wack_q.tbuf});
            default: bus_rdata = '0;
        endcase
    end

    assign tick_buf_o     = tbuf_q;
    assign evt_buf_o      = ebuf_q;
    assign ctrl_o         = ctrl_q;
    assign tick_start_o   = wr_c && ctrl_new.tick_run && !ctrl_q.tick_run;
    assign evt_start_o    = wr_c && ctrl_new.evt_run && !ctrl_q.evt_run;
    assign evt_load_o     = wr_e && bus_wdata[DATA_W-1];
    assign evt_load_val_o = bus_wdata[EVT_W-1:0];
    assign irq_o          = stat_q && ien_q;

    // R8: status only rises after an expiry from the event counter
    a_r8_status_source: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q) |-> $past(expire_i));
    // R10: tick buffer acknowledge only rises after a tick buffer write
    a_r10_ack_source: assert property (@(posedge clk) disable iff (rst)
        $rose(wack_q.tbuf) |-> $past(wr_t));

endmodule

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              start_i,
    input  logic [TICK_W-1:0] reload_i,
    output logic              tick_o
);
    logic [TICK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start_i)       cnt_q <= reload_i;
        else if (run_i) begin
            if (cnt_q == '0)    cnt_q <= reload_i;
            else                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R3: each tick restarts the prescaler from the buffer
    a_r3_reload_after_tick: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !start_i) |=> (cnt_q == $past(reload_i)));
    // R7: a stopped prescaler holds its count
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ctt_evtcnt.sv
module ctt_evtcnt #(
    parameter int EVT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             reload_mode_i,
    input  logic             start_i,
    input  logic             load_i,
    input  logic [EVT_W-1:0] load_val_i,
    input  logic [EVT_W-1:0] reload_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [EVT_W-1:0] cnt_q;
    logic             done_q;
    logic             active;

    assign active   = run_i && !done_q;
    assign expire_o = tick_i && active && !load_i && !start_i
                      && (cnt_q <= EVT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= reload_i;
            done_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= load_val_i;
        end else if (expire_o) begin
            if (reload_mode_i) cnt_q <= reload_i;
            else begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end
        end else if (tick_i && active) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6: a single-shot expiry leaves the counter idle
    a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !reload_mode_i) |=> done_q);
    // R5: an auto-reload expiry refills from the buffer
    a_r5_interval_reload: assert property (@(posedge clk) disable iff (rst)
        (expire_o && reload_mode_i) |=> (cnt_q == $past(reload_i)) && !done_q);
    // R4: a flagged buffer write lands in the counter
    a_r4_direct_load: assert property (@(posedge clk) disable iff (rst)
        (load_i && !start_i) |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import ctt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int EVT_W = DATA_W - 1;

    logic [TICK_W-1:0] tick_buf;
    logic [EVT_W-1:0]  evt_buf, evt_load_val;
    ctrl_t             ctrl;
    logic              tick_start, evt_start, evt_load, tick, expire;

    ctt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICK_W(TICK_W), .EVT_W(EVT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire_i(expire),
        .tick_buf_o(tick_buf), .evt_buf_o(evt_buf), .ctrl_o(ctrl),
        .tick_start_o(tick_start), .evt_start_o(evt_start),
        .evt_load_o(evt_load), .evt_load_val_o(evt_load_val),
        .irq_o(irq)
    );

    ctt_prescale #(.TICK_W(TICK_W)) u_pre (
        .clk(clk), .rst(rst),
        .run_i(ctrl.tick_run), .start_i(tick_start),
        .reload_i(tick_buf), .tick_o(tick)
    );

    ctt_evtcnt #(.EVT_W(EVT_W)) u_evt (
        .clk(clk), .rst(rst),
        .run_i(ctrl.evt_run), .reload_mode_i(ctrl.reload_mode),
        .start_i(evt_start), .load_i(evt_load), .load_val_i(evt_load_val),
        .reload_i(evt_buf), .tick_i(tick), .expire_o(expire)
    );

endmodule

// File: tb/sim_core_tick_timer.sv
module sim_core_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    core_tick_timer u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    // register-level vectors; req is the requirement number printed on failure
    localparam int NV = 21;
    localparam vec_t [0:NV-1] VECS = '{
        '{1'b0, 8'h00, 32'h0, 32'h0, 8'd1},          // R1 tick buffer reset
        '{1'b0, 8'h40, 32'h0, 32'h0, 8'd1},          // R1 ack reset
        '{1'b0, 8'h20, 32'h0, 32'h0, 8'd1},          // R1 control reset
        '{1'b1, 8'h00, 32'hDEADBEEF, 32'h0, 8'd2},
        '{1'b0, 8'h00, 32'h0, 32'hDEADBEEF, 8'd2},   // R2 full width
        '{1'b0, 8'h40, 32'h0, 32'h1, 8'd10},         // R10 bit0
        '{1'b1, 8'h08, 32'hFFFFFFFF, 32'h0, 8'd2},
        '{1'b0, 8'h08, 32'h0, 32'h7FFFFFFF, 8'd2},   // R2 top bit dropped
        '{1'b0, 8'h40, 32'h0, 32'h3, 8'd10},         // R10 bit1
        '{1'b1, 8'h34, 32'h1, 32'h0, 8'd2},
        '{1'b0, 8'h40, 32'h0, 32'h3, 8'd10},         // R10 enable write no ack
        '{1'b0, 8'h34, 32'h0, 32'h1, 8'd2},
        '{1'b1, 8'h20, 32'hFC, 32'h0, 8'd2},
        '{1'b0, 8'h20, 32'h0, 32'h4, 8'd2},          // R2 only bits 2:0
        '{1'b0, 8'h40, 32'h0, 32'hB, 8'd10},         // R10 bit3
        '{1'b1, 8'h40, 32'h1, 32'h0, 8'd10},
        '{1'b0, 8'h40, 32'h0, 32'hA, 8'd10},         // R10 single clear
        '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h0, 8'd10},
        '{1'b0, 8'h40, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h10, 32'h0, 32'h0, 8'd2},          // R2 unmapped
        '{1'b1, 8'h20, 32'h0, 32'h0, 8'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            n++;
            #2;
            if (irq) return;
        end
        n = -1;
    endtask

    task automatic halt_all();
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h1);
    endtask

    task automatic run_timing(input logic [31:0] t, input logic [31:0] e, input int expn);
        int n;
        halt_all();
        wr(8'h00, t);
        wr(8'h08, e);
        wr(8'h34, 32'h1);
        wr(8'h20, 32'h7);
        wait_irq(n);
        check("R3 first expiry cycle", n, expn);
        wr(8'h30, 32'h1);
        wait_irq(n);
        check("R5 reload spacing", n, expn - 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        logic quiet;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2 check("R1 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, d);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].expv);
            end
        end

        // R3 / R5 for several buffer pairs
        run_timing(32'd1, 32'd3, 6);
        run_timing(32'd0, 32'd4, 4);
        run_timing(32'd2, 32'd3, 9);
        rd(8'h30, d);
        check("R8 status after expiry", d, 32'h1);
        wr(8'h30, 32'h1);
        rd(8'h30, d);
        check("R8 status cleared", d, 32'h0);

        // R6 single shot
        halt_all();
        wr(8'h00, 32'd0);
        wr(8'h08, 32'd3);
        wr(8'h20, 32'h3);
        wait_irq(n);
        check("R6 single shot fires", n, 3);
        wr(8'h30, 32'h1);
        quiet = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #2;
            if (irq) quiet = 1'b0;
        end
        check("R6 stays idle", {31'b0, quiet}, 32'h1);
        wr(8'h20, 32'h0);
        wr(8'h20, 32'h3);
        wait_irq(n);
        check("R6 restart fires", n, 3);

        // R7 freeze and resume
        halt_all();
        wr(8'h00, 32'd3);
        wr(8'h08, 32'd2);
        wr(8'h20, 32'h3);
        repeat (5) @(posedge clk);
        wr(8'h20, 32'h2);
        repeat (20) @(posedge clk);
        rd(8'h30, d);
        check("R7 frozen no event", d, 32'h0);
        wr(8'h20, 32'h3);
        wait_irq(n);
        check("R7 resume keeps event count", n, 4);

        // R4 flagged load
        halt_all();
        wr(8'h00, 32'd0);
        wr(8'h08, 32'd10);
        wr(8'h20, 32'h7);
        wr(8'h08, 32'h80000002);
        wait_irq(n);
        check("R4 flagged load", n, 2);

        // R4 unflagged write affects only the next reload
        halt_all();
        wr(8'h08, 32'd10);
        wr(8'h20, 32'h7);
        wr(8'h08, 32'h00000002);
        wait_irq(n);
        check("R4 unflagged keeps count", n, 9);
        wr(8'h30, 32'h1);
        wait_irq(n);
        check("R4 new buffer at reload", n, 1);

        // R9 enable gating
        halt_all();
        wr(8'h34, 32'h0);
        wr(8'h08, 32'd2);
        wr(8'h20, 32'h3);
        repeat (10) @(posedge clk);
        rd(8'h30, d);
        check("R9 status set while masked", d, 32'h1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h34, 32'h1);
        #2 check("R9 irq unmasked", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h1);
        #2 check("R9 irq after clear", {31'b0, irq}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule